// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each channel raises a one-cycle fire pulse when its comparator matches. The router turns that pulse into an interrupt according to the channel's settings. A level-style channel latches a status bit and holds its line high until software clears the bit. An edge-style channel drives a single-cycle pulse on its line. A message-style channel drives no line. Instead it requests one 32-bit memory write whose address and data come from the channel's 64-bit route word.

A legacy replacement mode lets channels 0 and 1 take over two fixed lines, 0 and 8, whatever their route fields say. While this mode is on, the two external legacy interrupt sources are blocked from those lines, and an output that enables the legacy tick timer is dropped. Outside this mode the two external sources pass through to lines 0 and 8. The RTC-side input is registered in both modes, so line 8 shows its current level again as soon as legacy mode is left.

Top module: `timer_irq_router`

## Requirements
- R1: After reset all interrupt lines are low, `msg_req` is low, `stat` is zero and `tick_en` is high.
- R2: A fire on an enabled level-style channel (`ch_level`=1, `ch_msg`=0) sets its `stat` bit on the next clock edge. The bit stays set, and the routed line stays high, until the bit is cleared.
- R3: A fire on an enabled edge-style channel (`ch_level`=0, `ch_msg`=0) drives its routed line high for exactly one cycle and leaves its `stat` bit at 0.
- R4: A cycle with `stat_wr` high clears each `stat` bit that is set in both `stat_wdata` and `stat`, and it lowers that channel's line. Other bits are unchanged.
- R5: If a level-style fire and a status clear hit the same channel in the same cycle, the fire wins and the bit ends up set.
- R6: When a channel's `ch_en` is low, or when `glb_en` is low, that channel's `stat` bit is cleared on the next edge and its line drops.
- R7: A fire on an enabled message-style channel (`ch_msg`=1) pulses `msg_req` for one cycle. `msg_addr` takes bits 63:32 of the route word and `msg_data` takes bits 31:0. No line is raised and `stat` is unchanged. When several message channels fire together, the lowest index is used.
- R8: With `legacy_en` high, channel 0 drives line 0 and channel 1 drives line 8, ignoring their 5-bit route fields. Channels 2 and up always use their route fields.
- R9: With `legacy_en` low, `ext_tick` and `ext_rtc` appear on lines 0 and 8 one cycle after they are sampled. With `legacy_en` high both are blocked.
- R10: `tick_en` is the inverse of `legacy_en`, delayed by one cycle. After legacy mode is left, line 8 follows the latest `ext_rtc` level, including changes that happened during legacy mode.
- R11: A fire on a channel with `ch_en` low, or while `glb_en` is low, has no effect on lines, `stat` or `msg_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy replacement mode |
| ch_en | input | NCH | Per-channel interrupt enable |
| ch_level | input | NCH | 1 = level style, 0 = edge style |
| ch_msg | input | NCH | 1 = message-write delivery |
| ch_route | input | NCH*5 | Per-channel line number, channel i at bits [5i+4:5i] |
| ch_word | input | NCH*64 | Per-channel message word: address in the upper half, data in the lower half |
| fire | input | NCH | One-cycle fire pulses |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | NCH | Write-1-to-clear mask |
| ext_tick | input | 1 | External legacy tick interrupt level |
| ext_rtc | input | 1 | External RTC interrupt level |
| irq | output | NLINES | Interrupt lines |
| stat | output | NCH | Level status bits |
| msg_req | output | 1 | Message-write request pulse |
| msg_addr | output | 32 | Message-write address |
| msg_data | output | 32 | Message-write data |
| tick_en | output | 1 | Legacy tick timer enable |

## Verification
The collision of interest is a level-style fire that lands in the same cycle as a write-1-to-clear aimed at that same channel. A second, already-set channel is cleared by the same write. The bench provokes this by raising `fire` and `stat_wr` on one falling edge, so both are sampled on the same rising edge. The result is judged on `stat` and `irq`: the firing channel must stay set and keep its line high, and the other channel must be cleared. A second overlap is also checked: a legacy-mode toggle in the same cycle as an external-level change, judged by line 8 and `tick_en` after legacy mode is left.

// File: rtl/timer_irq_router.sv
module timer_irq_router #(
  parameter int NCH    = 4,
  parameter int NLINES = 32,
  parameter int LEG_A  = 0,
  parameter int LEG_B  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                glb_en,
  input  logic                legacy_en,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH-1:0]      ch_level,
  input  logic [NCH-1:0]      ch_msg,
  input  logic [NCH*$clog2(NLINES)-1:0] ch_route,
  input  logic [NCH*64-1:0]   ch_word,
  input  logic [NCH-1:0]      fire,
  input  logic                stat_wr,
  input  logic [NCH-1:0]      stat_wdata,
  input  logic                ext_tick,
  input  logic                ext_rtc,
  output logic [NLINES-1:0]   irq,
  output logic [NCH-1:0]      stat,
  output logic                msg_req,
  output logic [31:0]         msg_addr,
  output logic [31:0]         msg_data,
  output logic                tick_en
);
  localparam int RW = $clog2(NLINES);

  logic [NCH-1:0] live, hit, epulse, line_on;
  logic           tick_q, rtc_q;
  logic [RW-1:0]  dest [NCH];
  logic [NLINES-1:0] irq_c;

  assign live    = ch_en & {NCH{glb_en}};
  assign hit     = fire & live;
  assign line_on = stat | epulse;

  for (genvar g = 0; g < NCH; g++) begin : g_dest
    if (g == 0) begin : g_a
      assign dest[g] = legacy_en ? RW'(LEG_A) : ch_route[g*RW +: RW];
    end else if (g == 1) begin : g_b
      assign dest[g] = legacy_en ? RW'(LEG_B) : ch_route[g*RW +: RW];
    end else begin : g_n
      assign dest[g] = ch_route[g*RW +: RW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat     <= '0;
      epulse   <= '0;
      msg_req  <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
      tick_q   <= 1'b0;
      rtc_q    <= 1'b0;
      tick_en  <= 1'b1;
    end else begin
      tick_q  <= ext_tick;
      rtc_q   <= ext_rtc;
      tick_en <= !legacy_en;
      msg_req <= 1'b0;
      for (int i = NCH-1; i >= 0; i--) begin
        epulse[i] <= hit[i] && !ch_msg[i] && !ch_level[i];
        if (!live[i])
          stat[i] <= 1'b0;
        else if (hit[i] && !ch_msg[i])
          stat[i] <= ch_level[i];
        else if (stat_wr && stat_wdata[i])
          stat[i] <= 1'b0;
        if (hit[i] && ch_msg[i]) begin
          msg_req  <= 1'b1;
          msg_addr <= ch_word[i*64+32 +: 32];
          msg_data <= ch_word[i*64 +: 32];
        end
      end
    end
  end

  always_comb begin
    irq_c = '0;
    for (int i = 0; i < NCH; i++)
      if (line_on[i]) irq_c[dest[i]] = 1'b1;
    if (!legacy_en) begin
      irq_c[LEG_A] = irq_c[LEG_A] | tick_q;
      irq_c[LEG_B] = irq_c[LEG_B] | rtc_q;
    end
  end
  assign irq = irq_c;

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(stat_wr) |-> (stat & $past(stat_wdata) & ~$past(fire)) == '0);
  // R6
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(glb_en) |-> stat == '0 && !msg_req);
  // R7
  msg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(glb_en) && $past(|(fire & ch_msg & ch_en)));
  // R3
  edge_nostat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat & $past(fire & ch_en & ~ch_level & ~ch_msg & {NCH{glb_en}})) == '0);
  // R10
  tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(legacy_en) |-> !tick_en);
endmodule

// File: tb/test_timer_irq_router.sv
module test_timer_irq_router;
  localparam int NCH = 4;
  localparam int NL  = 32;
  localparam int RW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0, legacy_en = 1'b0, stat_wr = 1'b0, ext_tick = 1'b0, ext_rtc = 1'b0;
  logic [NCH-1:0] ch_en = '0, ch_level = '0, ch_msg = '0, fire = '0, stat_wdata = '0;
  logic [NCH*RW-1:0] ch_route = '0;
  logic [NCH*64-1:0] ch_word = '0;
  logic [NL-1:0] irq;
  logic [NCH-1:0] stat;
  logic msg_req, tick_en;
  logic [31:0] msg_addr, msg_data;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  timer_irq_router i_timer_irq_router (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_en(legacy_en),
    .ch_en(ch_en), .ch_level(ch_level), .ch_msg(ch_msg), .ch_route(ch_route),
    .ch_word(ch_word), .fire(fire), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ext_tick(ext_tick), .ext_rtc(ext_rtc), .irq(irq), .stat(stat),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data), .tick_en(tick_en));

  // {fire, level, expected irq, expected stat}; routes 2,5,17,31
  localparam logic [43:0] VEC [5] = '{
    {4'b0001, 4'b1111, 32'h0000_0004, 4'b0001},
    {4'b0110, 4'b1111, 32'h0002_0020, 4'b0110},
    {4'b1000, 4'b0000, 32'h8000_0000, 4'b0000},
    {4'b1011, 4'b0011, 32'h8000_0024, 4'b0011},
    {4'b0000, 4'b1111, 32'h0000_0000, 4'b0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    stat_wr = 1'b1; stat_wdata = '1; step(); stat_wr = 1'b0; stat_wdata = '0; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst_n = 1'b1; step();
    chk("R1 irq", 64'(irq), 0); chk("R1 stat", 64'(stat), 0);
    chk("R1 msg_req", 64'(msg_req), 0); chk("R1 tick_en", 64'(tick_en), 1);

    glb_en = 1'b1; ch_en = '1;
    ch_route = {5'd31, 5'd17, 5'd5, 5'd2};
    for (int v = 0; v < 5; v++) begin
      ch_level = VEC[v][39:36]; fire = VEC[v][43:40];
      step(); fire = '0;
      chk("R2 R3 vector irq", 64'(irq), 64'(VEC[v][35:4]));
      chk("R2 R3 vector stat", 64'(stat), 64'(VEC[v][3:0]));
      clear_all();
    end

    ch_level = '1; fire = 4'b0001; step(); fire = '0; step(); step();
    chk("R2 hold irq", 64'(irq), 64'h4); chk("R2 hold stat", 64'(stat), 1);

    fire = 4'b0010; step(); fire = '0;
    stat_wr = 1'b1; stat_wdata = 4'b0101; step(); stat_wr = 1'b0;
    chk("R4 partial stat", 64'(stat), 64'b0010); chk("R4 partial irq", 64'(irq), 64'h20);

    fire = 4'b0001; stat_wr = 1'b1; stat_wdata = 4'b0011; step(); fire = '0; stat_wr = 1'b0;
    chk("R5 collide stat", 64'(stat), 64'b0001); chk("R5 collide irq", 64'(irq), 64'h4);
    clear_all();

    fire = 4'b0011; step(); fire = '0; ch_en = 4'b1110; step();
    chk("R6 ch off stat", 64'(stat), 64'b0010); chk("R6 ch off irq", 64'(irq), 64'h20);
    glb_en = 1'b0; step();
    chk("R6 glb off stat", 64'(stat), 0); chk("R6 glb off irq", 64'(irq), 0);
    ch_en = '1; fire = 4'b0001; step(); fire = '0;
    chk("R11 glb off fire", 64'({irq, 3'b0, msg_req, stat}), 0);
    glb_en = 1'b1; ch_en = 4'b1110; ch_level = '0; fire = 4'b0001; step(); fire = '0;
    chk("R11 ch off fire", 64'({irq, 3'b0, msg_req, stat}), 0);
    ch_en = '1;

    fire = 4'b0100; step(); fire = '0;
    chk("R3 edge high", 64'(irq), 64'h0002_0000); chk("R3 edge stat", 64'(stat), 0);
    step();
    chk("R3 edge gone", 64'(irq), 0);

    ch_level = '1; ch_msg = 4'b0110;
    ch_word[64 +: 64]  = 64'h1111_2222_3333_4444;
    ch_word[128 +: 64] = 64'hAAAA_BBBB_CCCC_DDDD;
    fire = 4'b0110; step(); fire = '0;
    chk("R7 req", 64'(msg_req), 1); chk("R7 addr", 64'(msg_addr), 64'h1111_2222);
    chk("R7 data", 64'(msg_data), 64'h3333_4444); chk("R7 no line", 64'(irq), 0);
    chk("R7 stat", 64'(stat), 0);
    step();
    chk("R7 req once", 64'(msg_req), 0);
    ch_msg = '0;

    legacy_en = 1'b1; step();
    chk("R10 tick off", 64'(tick_en), 0);
    fire = 4'b0111; step(); fire = '0;
    chk("R8 legacy irq", 64'(irq), 64'h0002_0101); chk("R8 legacy stat", 64'(stat), 64'b0111);
    clear_all();

    legacy_en = 1'b0; ext_tick = 1'b1; ext_rtc = 1'b1; step();
    chk("R9 pass", 64'(irq), 64'h101); chk("R10 tick on", 64'(tick_en), 1);
    legacy_en = 1'b1; step();
    chk("R9 blocked", 64'(irq), 0);
    ext_rtc = 1'b0; step(); ext_rtc = 1'b1; step();
    chk("R9 blocked rtc", 64'(irq), 0);
    legacy_en = 1'b0; step();
    chk("R10 restore irq", 64'(irq), 64'h101); chk("R10 restore tick", 64'(tick_en), 1);
    ext_tick = 1'b0; ext_rtc = 1'b0; step();
    chk("R9 follow low", 64'(irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule